// File: doc/BRIEF.md
# Four-Phase Cross-Domain Request Handshake

This block carries a single request event from one clock domain to a second, unrelated clock domain. It uses a four-phase return-to-zero handshake. A sender state machine runs on the source clock and accepts a one-cycle start pulse. It raises a request level and waits for the receiver's acknowledge. It then drops the request and waits for the acknowledge to fall again. A receiver state machine runs on the destination clock. It answers the request level with an acknowledge level, and it gives a one-cycle event pulse in its own domain each time a new request arrives.

Each level that crosses between the domains comes straight from a flip-flop in the launching domain, so no combinational glitch can cross. Each level received from the other domain passes through a two-stage synchronizer before either state machine uses it. The sender reports a busy level for the whole of a transaction and a one-cycle done pulse when the transaction closes. Each domain has its own asynchronous active-low reset.

Top module: `hs_req_bridge`

## Requirements
- R1: While both resets are asserted, `busy_o`, `done_o`, `event_o`, `req_line_o` and `ack_line_o` are all 0.
- R2: When `start_i` is 1 at a source clock edge and `busy_o` is 0, then `busy_o` and `req_line_o` are both 1 after that edge.
- R3: A `start_i` pulse seen while `busy_o` is 1 is ignored. It adds no event pulse and no done pulse, and the number of `event_o` pulses equals the number of accepted starts.
- R4: `ack_line_o` rises exactly at the third destination clock edge after `req_line_o` rises. This is two synchronizer stages plus one state register.
- R5: `event_o` is 1 for exactly one destination clock cycle, and it is asserted in the same cycle that `ack_line_o` rises.
- R6: `req_line_o` falls only after the synchronized acknowledge reads 1. It falls exactly at the third source clock edge after `ack_line_o` rises.
- R7: `ack_line_o` falls exactly at the third destination clock edge after `req_line_o` falls.
- R8: `done_o` pulses for one source clock cycle exactly at the third source clock edge after `ack_line_o` falls. From that edge on, `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_t_i | input | 1 | Source-side clock |
| rst_t_ni | input | 1 | Source-side asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, source domain |
| busy_o | output | 1 | Transaction in progress, source domain |
| done_o | output | 1 | One-cycle pulse when a transaction closes, source domain |
| req_line_o | output | 1 | Registered request level sent to the destination |
| clk_l_i | input | 1 | Destination-side clock |
| rst_l_ni | input | 1 | Destination-side asynchronous active-low reset |
| event_o | output | 1 | One-cycle pulse per received request, destination domain |
| ack_line_o | output | 1 | Registered acknowledge level sent to the source |

## Verification
Within the source domain, busy and the request level are due one source edge after an accepted start. Every other result is due a whole number of edges after a level change in the other domain: three destination edges for the acknowledge rise, the acknowledge fall and the event pulse, and three source edges for the request fall and for done. The two clock periods never put a source edge and a destination edge at the same instant. The bench therefore counts edges of the receiving clock from each observed level change, and it samples one nanosecond after each edge. The check for ignored starts compares the event and done totals with the number of starts the bench model accepted.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    T_IDLE   = 2'd0,
    T_REQ_HI = 2'd1,
    T_REQ_LO = 2'd2
  } talk_st_e;

  typedef enum logic {
    L_IDLE = 1'b0,
    L_ACK  = 1'b1
  } lstn_st_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_talker.sv
module hs_talker
  import hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_sync_i,
  output logic req_o,
  output logic busy_o,
  output logic done_o
);
  talk_st_e state_q, state_d;
  logic     req_q, done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      T_IDLE:   if (start_i)     state_d = T_REQ_HI;
      T_REQ_HI: if (ack_sync_i)  state_d = T_REQ_LO;
      T_REQ_LO: if (!ack_sync_i) state_d = T_IDLE;
      default:                   state_d = T_IDLE;
    endcase
  end

  // Outgoing level comes straight from a flop, never from logic
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= T_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d == T_REQ_HI);
      done_q  <= (state_q == T_REQ_LO) && (state_d == T_IDLE);
    end
  end

  assign req_o  = req_q;
  assign busy_o = (state_q != T_IDLE);
  assign done_o = done_q;

  // R2
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(start_i));
  // R6
  req_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_sync_i));
  // R8
  done_ack_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !$past(ack_sync_i) && !busy_o);
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/hs_listener.sv
module hs_listener
  import hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_sync_i,
  output logic ack_o,
  output logic event_o
);
  lstn_st_e state_q, state_d;
  logic     ack_q, ev_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      L_IDLE:  if (req_sync_i)  state_d = L_ACK;
      L_ACK:   if (!req_sync_i) state_d = L_IDLE;
      default:                  state_d = L_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= L_IDLE;
      ack_q   <= 1'b0;
      ev_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == L_ACK);
      ev_q    <= (state_q == L_IDLE) && (state_d == L_ACK);
    end
  end

  assign ack_o   = ack_q;
  assign event_o = ev_q;

  // R4
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> $past(req_sync_i));
  // R7
  ack_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_q) |-> !$past(req_sync_i));
  // R5
  event_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q |=> !ev_q);
  // R5
  event_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q |-> ack_q);
endmodule

// File: rtl/hs_req_bridge.sv
module hs_req_bridge
  import hs_pkg::*;
(
  input  logic clk_t_i,
  input  logic rst_t_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic req_line_o,
  input  logic clk_l_i,
  input  logic rst_l_ni,
  output logic event_o,
  output logic ack_line_o
);
  logic req_lvl, ack_lvl;
  logic req_sync, ack_sync;

  hs_talker i_talker (
    .clk_i      (clk_t_i),
    .rst_ni     (rst_t_ni),
    .start_i    (start_i),
    .ack_sync_i (ack_sync),
    .req_o      (req_lvl),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) i_sync_ack (
    .clk_i  (clk_t_i),
    .rst_ni (rst_t_ni),
    .d_i    (ack_lvl),
    .q_o    (ack_sync)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) i_sync_req (
    .clk_i  (clk_l_i),
    .rst_ni (rst_l_ni),
    .d_i    (req_lvl),
    .q_o    (req_sync)
  );

  hs_listener i_listener (
    .clk_i      (clk_l_i),
    .rst_ni     (rst_l_ni),
    .req_sync_i (req_sync),
    .ack_o      (ack_lvl),
    .event_o    (event_o)
  );

  assign req_line_o = req_lvl;
  assign ack_line_o = ack_lvl;

  // R3
  busy_no_req_rise_chk: assert property (@(posedge clk_t_i) disable iff (!rst_t_ni)
    $past(busy_o) |-> !$rose(req_lvl));
endmodule

// File: tb/test_hs_req_bridge.sv
`timescale 1ns/100ps
module test_hs_req_bridge;
  logic clk_t = 1'b0, clk_l = 1'b0;
  logic rst_t_n = 1'b0, rst_l_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, req_line, event_p, ack_line;

  int checks = 0, errors = 0;
  int accepted = 0, events = 0, dones = 0;
  bit run_on = 1'b0, finished = 1'b0;

  always #2.5 clk_t = ~clk_t;          // 200 MHz
  initial begin
    #1.3;
    forever #3.5 clk_l = ~clk_l;       // unrelated destination clock
  end

  hs_req_bridge i_hs_req_bridge (
    .clk_t_i(clk_t), .rst_t_ni(rst_t_n), .start_i(start),
    .busy_o(busy), .done_o(done), .req_line_o(req_line),
    .clk_l_i(clk_l), .rst_l_ni(rst_l_n),
    .event_o(event_p), .ack_line_o(ack_line)
  );

  function automatic bit accept_start(bit b, bit s);
    return s && !b;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4 R5 R7: destination-side timing
  initial begin
    wait (run_on);
    forever begin
      int n;
      @(posedge req_line);
      n = 0;
      do begin @(posedge clk_l); #1; n++; end while (!ack_line && n < 20);
      check("R4 ack rise edges", n, 3);
      check("R5 event with ack", int'(event_p), 1);
      if (event_p) events++;
      @(posedge clk_l); #1;
      check("R5 event width", int'(event_p), 0);
      @(negedge req_line);
      n = 0;
      do begin @(posedge clk_l); #1; n++; end while (ack_line && n < 20);
      check("R7 ack fall edges", n, 3);
    end
  end

  // R6 R8: source-side timing
  initial begin
    wait (run_on);
    forever begin
      int n;
      @(posedge ack_line);
      n = 0;
      do begin @(posedge clk_t); #1; n++; end while (req_line && n < 20);
      check("R6 req fall edges", n, 3);
      @(negedge ack_line);
      n = 0;
      do begin @(posedge clk_t); #1; n++; end while (!done && n < 20);
      check("R8 done edges", n, 3);
      check("R8 busy low at done", int'(busy), 0);
      if (done) dones++;
      @(posedge clk_t); #1;
      check("R8 done width", int'(done), 0);
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #20;
    @(negedge clk_t);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 event", int'(event_p), 0);
    check("R1 req", int'(req_line), 0);
    check("R1 ack", int'(ack_line), 0);
    rst_t_n = 1'b1;
    rst_l_n = 1'b1;
    run_on = 1'b1;
    repeat (3) @(negedge clk_t);

    // directed: start, then a start while busy (R3)
    for (int k = 0; k < 600; k++) begin
      bit s, acc;
      @(negedge clk_t);
      if (k < 2) s = 1'b1;
      else       s = ($urandom_range(0, 3) == 0);
      start = s;
      acc = accept_start(busy, s);
      @(posedge clk_t); #1;
      start = 1'b0;
      if (acc) begin
        accepted++;
        check("R2 busy after start", int'(busy), 1);
        check("R2 req after start", int'(req_line), 1);
      end
    end
    wait (!busy);
    repeat (40) @(negedge clk_t);
    check("R3 events vs accepted", events, accepted);
    check("R3 dones vs accepted", dones, accepted);
    check("R3 some starts accepted", int'(accepted > 10), 1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule